// File: doc/BRIEF.md
# Two-Thread Group Completion Table

This block keeps track of instruction groups from two hardware threads between dispatch and commit. Every dispatched group takes one slot of a shared 20-slot table. The slot records the owning thread, how many instructions the group holds (one to five), which of them have finished, and whether any of them raised an exception. Slots are handed out in dispatch order, so the groups of the two threads sit side by side in the same table.

Execution units name a slot and an instruction position within the group when that instruction finishes. They can also mark the finish as faulting. Each thread keeps its own ordered list of slot indices, so its oldest group is always at the head of that list. A group leaves the table when it is complete, fault-free and the oldest of its thread. Each thread can retire one group per cycle, so a group of one thread may leave before older groups of the other thread. A complete group that carries a fault stays in place and raises a per-thread exception output until that thread is flushed.

A flush drops every group of one thread in a single cycle. Dispatch must stall while the full output is high.

Top module: `gct_table`

## Requirements
- R1: After synchronous reset the table is empty: full is 0, disp_idx is 0, commit_valid is 00 and exc_flag is 00.
- R2: A dispatch is accepted when disp_valid is 1, full is 0 and flush is 0 for disp_tid. It takes the lowest free slot, which disp_idx shows before the clock edge, and stores disp_tid and disp_count (1 to 5).
- R3: A finish report (fin_valid, fin_idx, fin_slot 0..count-1, fin_exc) marks that instruction of a valid slot as done and ORs fin_exc into the slot's fault bit. A report to an empty slot has no effect.
- R4: commit_valid[t] is 1, with commit_idx_t giving the slot, in the cycle after the last instruction of a group is reported. This holds only when the group is the oldest of thread t and has no fault.
- R5: Within one thread, groups commit in dispatch order. A younger group that is complete waits behind an older group that is not. The other thread's complete head group commits regardless.
- R6: Both threads can commit in the same cycle.
- R7: A committed slot is free after the commit edge, and its index is offered to dispatch again.
- R8: A complete group whose fault bit is set never commits. It holds exc_flag[t] at 1 until thread t is flushed.
- R9: flush[t] frees all of thread t's slots at the next edge and drops a dispatch to thread t in the same cycle. It holds commit_valid[t] at 0 while asserted and leaves the other thread's groups intact.
- R10: full is 1 when all 20 slots are in use. A dispatch while full is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 1 | Dispatch request |
| disp_tid | input | 1 | Thread of the dispatched group |
| disp_count | input | 3 | Instructions in the group, 1 to 5 |
| disp_idx | output | 5 | Slot the next dispatch will take |
| full | output | 1 | No free slot |
| fin_valid | input | 1 | Finish report valid |
| fin_idx | input | 5 | Slot of the finished instruction |
| fin_slot | input | 3 | Position of the instruction in its group |
| fin_exc | input | 1 | Instruction faulted |
| flush | input | 2 | Per-thread flush |
| commit_valid | output | 2 | Per-thread commit this cycle |
| commit_idx0 | output | 5 | Slot committing for thread 0 |
| commit_idx1 | output | 5 | Slot committing for thread 1 |
| exc_flag | output | 2 | Per-thread faulted head group |

## Verification
The bench finishes a younger group first to catch a design that commits out of order within a thread. It also interleaves the two threads, so a design that retires in global order would stall a ready group. Four groups are placed so that both threads' heads become ready on the same edge, which catches a design that retires only one group per cycle. A flush is combined with a same-thread dispatch, and the new group's commit is then checked: a design that kept the dropped dispatch or left stale indices in the order list would never commit it. The bench also fills the table and pushes one more dispatch, then checks that a faulted head group keeps its flag and never commits.

// File: rtl/gct_pkg.sv
package gct_pkg;
    localparam int GCT_ENTRIES = 20;
    localparam int GCT_GRP     = 5;
    localparam int GCT_NTHR    = 2;
    localparam int GCT_IW      = $clog2(GCT_ENTRIES);
    localparam int GCT_CW      = $clog2(GCT_GRP + 1);
    localparam int GCT_SW      = $clog2(GCT_GRP);

    typedef struct packed {
        logic               vld;
        logic               tid;
        logic [GCT_GRP-1:0] need;
        logic [GCT_GRP-1:0] done;
        logic               exc;
    } gct_entry_t;

    function automatic logic [GCT_GRP-1:0] need_mask(input logic [GCT_CW-1:0] cnt);
        logic [GCT_GRP-1:0] m;
        for (int i = 0; i < GCT_GRP; i++) m[i] = (i < int'(cnt));
        return m;
    endfunction
endpackage

// File: rtl/gct_alloc.sv
module gct_alloc #(
    parameter int N = 20,
    localparam int W = $clog2(N)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] busy,
    output logic         full,
    output logic [W-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--)
            if (!busy[i]) idx = W'(i);
    end
    assign full = &busy;

    a_r2_pick_free: assert property (@(posedge clk) disable iff (rst)
        !full |-> !busy[idx]);
    a_r2_pick_lowest: assert property (@(posedge clk) disable iff (rst)
        !full |-> ((busy & ((N'(1) << idx) - N'(1))) == (((N'(1) << idx) - N'(1)))));
endmodule

// File: rtl/gct_idx_fifo.sv
module gct_idx_fifo #(
    parameter int DEPTH = 20,
    parameter int W = 5,
    localparam int PW = $clog2(DEPTH),
    localparam int CNW = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic         empty,
    output logic [W-1:0] head
);
    logic [W-1:0]   mem [DEPTH];
    logic [PW-1:0]  wp, rp;
    logic [CNW-1:0] cnt;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) begin
                mem[wp] <= push_data;
                wp      <= bump(wp);
            end
            if (pop) rp <= bump(rp);
            cnt <= cnt + CNW'(push) - CNW'(pop);
        end
    end

    assign empty = (cnt == '0);
    assign head  = mem[rp];

    a_r10_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (push && !clr) |-> (cnt < CNW'(DEPTH)));
    a_r5_no_underflow: assert property (@(posedge clk) disable iff (rst)
        (pop && !clr) |-> !empty);
endmodule

// File: rtl/gct_table.sv
module gct_table
    import gct_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              disp_valid,
    input  logic              disp_tid,
    input  logic [GCT_CW-1:0] disp_count,
    output logic [GCT_IW-1:0] disp_idx,
    output logic              full,
    input  logic              fin_valid,
    input  logic [GCT_IW-1:0] fin_idx,
    input  logic [GCT_SW-1:0] fin_slot,
    input  logic              fin_exc,
    input  logic [1:0]        flush,
    output logic [1:0]        commit_valid,
    output logic [GCT_IW-1:0] commit_idx0,
    output logic [GCT_IW-1:0] commit_idx1,
    output logic [1:0]        exc_flag
);
    gct_entry_t               tab [GCT_ENTRIES];
    logic [GCT_ENTRIES-1:0]   busy;
    logic [GCT_IW-1:0]        head_idx [GCT_NTHR];
    logic [GCT_NTHR-1:0]      q_empty;
    logic [GCT_NTHR-1:0]      thr_busy;
    logic                     accept;
    logic [GCT_GRP-1:0]       fin_bit;

    always_comb begin
        thr_busy = '0;
        for (int i = 0; i < GCT_ENTRIES; i++) begin
            busy[i] = tab[i].vld;
            if (tab[i].vld) thr_busy[tab[i].tid] = 1'b1;
        end
    end

    gct_alloc #(.N(GCT_ENTRIES)) u_alloc (
        .clk(clk), .rst(rst), .busy(busy), .full(full), .idx(disp_idx));

    assign accept  = disp_valid && !full && !flush[disp_tid];
    assign fin_bit = GCT_GRP'(1) << fin_slot;

    for (genvar t = 0; t < GCT_NTHR; t++) begin : g_thr
        gct_entry_t hd;
        logic       ready;

        gct_idx_fifo #(.DEPTH(GCT_ENTRIES), .W(GCT_IW)) u_order (
            .clk(clk), .rst(rst), .clr(flush[t]),
            .push(accept && (disp_tid == 1'(t))), .push_data(disp_idx),
            .pop(commit_valid[t]), .empty(q_empty[t]), .head(head_idx[t]));

        assign hd    = tab[head_idx[t]];
        assign ready = !q_empty[t] && hd.vld && ((hd.done | ~hd.need) == '1);
        assign commit_valid[t] = ready && !hd.exc && !flush[t];
        assign exc_flag[t]     = ready && hd.exc;

        a_r9_flush_clears: assert property (@(posedge clk) disable iff (rst)
            flush[t] |=> !thr_busy[t]);
        a_r8_exc_sticky: assert property (@(posedge clk) disable iff (rst)
            (exc_flag[t] && !flush[t]) |=> exc_flag[t]);
        a_r5_head_owner: assert property (@(posedge clk) disable iff (rst)
            commit_valid[t] |-> (tab[head_idx[t]].tid == 1'(t)));
    end

    assign commit_idx0 = head_idx[0];
    assign commit_idx1 = head_idx[1];

    always_ff @(posedge clk) begin
        for (int i = 0; i < GCT_ENTRIES; i++) begin
            if (rst) begin
                tab[i] <= '0;
            end else if (tab[i].vld && (flush[tab[i].tid] ||
                     (commit_valid[tab[i].tid] && head_idx[tab[i].tid] == GCT_IW'(i)))) begin
                tab[i].vld <= 1'b0;
            end else if (accept && disp_idx == GCT_IW'(i)) begin
                tab[i] <= '{vld: 1'b1, tid: disp_tid, need: need_mask(disp_count),
                            done: '0, exc: 1'b0};
            end else if (fin_valid && tab[i].vld && fin_idx == GCT_IW'(i)) begin
                tab[i].done <= tab[i].done | fin_bit;
                tab[i].exc  <= tab[i].exc | fin_exc;
            end
        end
    end

    a_r7_free_on_commit: assert property (@(posedge clk) disable iff (rst)
        commit_valid[0] |=> !tab[$past(commit_idx0)].vld);
    a_r10_full_blocks: assert property (@(posedge clk) disable iff (rst)
        (full && !commit_valid[0] && !commit_valid[1] && flush == 2'b00) |=> full);
endmodule

// File: tb/gct_table_bench.sv
module gct_table_bench;
    import gct_pkg::*;

    logic              clk = 1'b0;
    logic              rst;
    logic              disp_valid;
    logic              disp_tid;
    logic [GCT_CW-1:0] disp_count;
    logic [GCT_IW-1:0] disp_idx;
    logic              full;
    logic              fin_valid;
    logic [GCT_IW-1:0] fin_idx;
    logic [GCT_SW-1:0] fin_slot;
    logic              fin_exc;
    logic [1:0]        flush;
    logic [1:0]        commit_valid;
    logic [GCT_IW-1:0] commit_idx0;
    logic [GCT_IW-1:0] commit_idx1;
    logic [1:0]        exc_flag;

    int runs = 0;
    int fails = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    gct_table u_gct_table (.*);

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        runs++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic dispatch(input bit tid, input int cnt, input int exp_idx);
        chk(disp_idx == GCT_IW'(exp_idx), "R2 disp_idx", disp_idx, exp_idx);
        disp_valid = 1'b1; disp_tid = tid; disp_count = GCT_CW'(cnt);
        step();
        disp_valid = 1'b0;
    endtask

    task automatic finish(input int idx, input int slot, input bit exc);
        fin_valid = 1'b1; fin_idx = GCT_IW'(idx); fin_slot = GCT_SW'(slot); fin_exc = exc;
        step();
        fin_valid = 1'b0; fin_exc = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1; disp_valid = 0; disp_tid = 0; disp_count = 0;
        fin_valid = 0; fin_idx = 0; fin_slot = 0; fin_exc = 0; flush = 0;
        step(); step();
        rst = 1'b0;
        step();
        chk(!full, "R1 full", full, 0);
        chk(disp_idx == 0, "R1 disp_idx", disp_idx, 0);
        chk(commit_valid == 0, "R1 commit_valid", commit_valid, 0);
        chk(exc_flag == 0, "R1 exc_flag", exc_flag, 0);
    endtask

    task automatic t_basic();
        finish(5, 0, 0);
        chk(disp_idx == 0, "R3 report to empty slot", disp_idx, 0);
        dispatch(0, 2, 0);
        finish(0, 0, 0);
        chk(commit_valid == 0, "R4 partial group", commit_valid, 0);
        finish(0, 1, 0);
        chk(commit_valid == 2'b01, "R4 commit", commit_valid, 1);
        chk(commit_idx0 == 0, "R4 commit_idx0", commit_idx0, 0);
        step();
        chk(commit_valid == 0, "R7 after commit", commit_valid, 0);
        chk(disp_idx == 0, "R7 slot reused", disp_idx, 0);
    endtask

    task automatic t_order();
        dispatch(0, 1, 0);
        dispatch(1, 1, 1);
        dispatch(0, 1, 2);
        dispatch(1, 1, 3);
        finish(2, 0, 0);
        chk(commit_valid == 0, "R5 younger waits", commit_valid, 0);
        finish(3, 0, 0);
        chk(commit_valid == 0, "R5 younger waits t1", commit_valid, 0);
        finish(0, 0, 0);
        chk(commit_valid == 2'b01, "R5 oldest t0 commits", commit_valid, 1);
        chk(commit_idx0 == 0, "R5 commit_idx0", commit_idx0, 0);
        finish(1, 0, 0);
        chk(commit_valid == 2'b11, "R6 dual commit", commit_valid, 3);
        chk(commit_idx0 == 2, "R6 commit_idx0", commit_idx0, 2);
        chk(commit_idx1 == 1, "R6 commit_idx1", commit_idx1, 1);
        step();
        chk(commit_valid == 2'b10, "R5 t1 next", commit_valid, 2);
        chk(commit_idx1 == 3, "R5 commit_idx1", commit_idx1, 3);
        step();
        chk(commit_valid == 0, "R7 drained", commit_valid, 0);
        chk(disp_idx == 0, "R7 drained idx", disp_idx, 0);
    endtask

    task automatic t_exception();
        dispatch(1, 2, 0);
        finish(0, 0, 1);
        chk(exc_flag == 0, "R8 not yet complete", exc_flag, 0);
        finish(0, 1, 0);
        chk(exc_flag == 2'b10, "R8 exc_flag", exc_flag, 2);
        chk(commit_valid == 0, "R8 no commit", commit_valid, 0);
        step(); step(); step();
        chk(exc_flag == 2'b10, "R8 held", exc_flag, 2);
        chk(commit_valid == 0, "R8 still no commit", commit_valid, 0);
        flush = 2'b10;
        #1;
        chk(commit_valid == 0, "R9 commit off during flush", commit_valid, 0);
        step();
        flush = 2'b00;
        #1;
        chk(exc_flag == 0, "R9 flush clears exc", exc_flag, 0);
        chk(disp_idx == 0, "R9 slot freed", disp_idx, 0);
    endtask

    task automatic t_flush();
        dispatch(0, 1, 0);
        dispatch(1, 1, 1);
        dispatch(1, 1, 2);
        dispatch(0, 2, 3);
        flush = 2'b10; disp_valid = 1'b1; disp_tid = 1'b1; disp_count = 1;
        step();
        flush = 2'b00; disp_valid = 1'b0;
        #1;
        chk(disp_idx == 1, "R9 t1 slots freed", disp_idx, 1);
        dispatch(1, 1, 1);
        finish(1, 0, 0);
        chk(commit_valid == 2'b10, "R9 dropped dispatch left no trace", commit_valid, 2);
        chk(commit_idx1 == 1, "R9 commit_idx1", commit_idx1, 1);
        finish(0, 0, 0);
        chk(commit_valid == 2'b01, "R9 t0 untouched", commit_valid, 1);
        chk(commit_idx0 == 0, "R9 commit_idx0", commit_idx0, 0);
        step();
        finish(3, 0, 0);
        finish(3, 1, 0);
        chk(commit_valid == 2'b01, "R9 t0 second group", commit_valid, 1);
        chk(commit_idx0 == 3, "R9 commit_idx0 3", commit_idx0, 3);
        step();
        chk(commit_valid == 0, "R7 empty again", commit_valid, 0);
    endtask

    task automatic t_full();
        for (int i = 0; i < GCT_ENTRIES; i++) dispatch(0, 1, i);
        chk(full, "R10 full", full, 1);
        disp_valid = 1'b1; disp_tid = 1'b1; disp_count = 1;
        step();
        disp_valid = 1'b0;
        chk(full, "R10 still full", full, 1);
        for (int i = 0; i < GCT_ENTRIES; i++) begin
            finish(i, 0, 0);
            chk(commit_valid == 2'b01, "R10 only t0 commits", commit_valid, 1);
            chk(commit_idx0 == GCT_IW'(i), "R10 commit order", commit_idx0, i);
        end
        step();
        chk(commit_valid == 0, "R10 ignored dispatch absent", commit_valid, 0);
        chk(!full && disp_idx == 0, "R10 empty", disp_idx, 0);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_order();
        t_exception();
        t_flush();
        t_full();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", runs, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            runs++;
            fails++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("[TB] %0d tests run, %0d failed", runs, fails);
            $finish;
        end
    end
endmodule